// File: doc/BRIEF.md
# Indexed Configuration and I/O Window

This block sits inside a bridge's register window and gives software indirect reach into a downstream configuration space and a downstream I/O space. Software first loads an index register with a target address and then touches a small data window. Each data-window access is turned into one downstream request whose address is the index with its two lowest bits dropped, joined with the byte offset used inside the window.

The register-port side carries a target select, a byte offset, a size code, a write flag and write data, and is held until the block answers with a one-cycle ready pulse. The downstream side presents address, size, direction, space (configuration or I/O) and lane-aligned write data, and returns read data with a valid strobe. Configuration traffic keeps little-endian byte order, while I/O traffic is byte-reversed within the access so that it travels big-endian. Access sizes that do not fit the offset are refused with an error and never reach the downstream side.

Top module: `idxp_window_port`

## Requirements
- R1: A 4-byte write to the index target (select code 0) stores all 32 bits, including bits 1:0; a 4-byte read of the index returns that value unchanged; both complete one cycle after acceptance without a downstream request.
- R2: A 1-byte or 2-byte access to the index target returns an error with read data all ones and leaves the stored index unchanged.
- R3: A forwarded request carries address bits 31:2 from the index and bits 1:0 from the window offset, whatever the value of index bit 31.
- R4: Size code 0 is one byte, 1 is two bytes, 2 is four bytes and 3 is illegal; in the data window a size is legal only when the offset is a multiple of its byte count (offset 0: 1/2/4, offset 2: 1/2, offsets 1 and 3: 1 only).
- R5: An illegal data-window access, or any access with select code 3, returns an error with read data all ones and issues no downstream request.
- R6: Configuration accesses (select code 1) keep byte order: value byte k travels on lane k, and lanes at or above the access size are zero.
- R7: I/O accesses (select code 2) reverse byte order inside the access: for N bytes, value byte k travels on lane N-1-k, lanes at or above N are zero, in both directions.
- R8: A forwarded read answers in the cycle after the downstream read-valid strobe and not before.
- R9: A forwarded write answers in the cycle after the downstream side accepts the request.
- R10: While a downstream request waits for acceptance it stays asserted with address, size, direction, space and data unchanged.
- R11: After reset the index is zero and neither the ready pulse nor a downstream request is asserted.
- R12: The ready pulse lasts exactly one cycle, and no downstream request is asserted in a cycle where it is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_valid | input | 1 | Register-port access request, held until s_ready |
| s_write | input | 1 | 1 = write, 0 = read |
| s_tgt | input | 2 | 0 index, 1 configuration data, 2 I/O data, 3 reserved |
| s_off | input | 2 | Byte offset inside the window |
| s_size | input | 2 | Size code: 0 byte, 1 halfword, 2 word, 3 illegal |
| s_wdata | input | 32 | Write value, right-aligned |
| s_ready | output | 1 | One-cycle completion pulse |
| s_rdata | output | 32 | Read value, right-aligned, valid with s_ready |
| s_err | output | 1 | Error flag, valid with s_ready |
| d_valid | output | 1 | Downstream request |
| d_ready | input | 1 | Downstream acceptance |
| d_write | output | 1 | Downstream direction |
| d_io | output | 1 | 1 = I/O space, 0 = configuration space |
| d_addr | output | 32 | Downstream byte address |
| d_size | output | 2 | Downstream size code |
| d_wdata | output | 32 | Lane-ordered write data |
| d_rvalid | input | 1 | Downstream read data strobe |
| d_rdata | input | 32 | Lane-ordered read data |

## Verification
On every cycle the assertions watch that a pending downstream request holds still, that anything forwarded has a size legal for its offset and an address whose upper bits match the index, that error answers carry all ones, that the index only moves after an accepted word write, and that the ready pulse is single and never overlaps a request. The byte-lane orders of the two spaces, the exact address composition including the bit-31 case, the refusal of every illegal offset and size pair and the one-cycle spacing between downstream strobes and the answer are only shown by the bench's scenarios, which compare every answer and every downstream request against a model held in queues.

// File: rtl/idxp_pkg.sv
package idxp_pkg;

   typedef enum logic [1:0] {
      TGT_INDEX = 2'd0,
      TGT_CFG   = 2'd1,
      TGT_IO    = 2'd2,
      TGT_NONE  = 2'd3
   } tgt_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2,
      ST_RESP  = 2'd3
   } seq_e;

endpackage

// File: rtl/idxp_size_check.sv
module idxp_size_check #(
   parameter int LANES = 4,
   parameter int OFF_W = 2,
   parameter int SZ_W  = 2
) (
   input  logic [OFF_W-1:0] off,
   input  logic [SZ_W-1:0]  size,
   input  logic             whole_only,
   output logic             legal
);

   always_comb begin
      int nb;
      logic [OFF_W-1:0] mask;
      nb   = 1 << size;
      mask = '0;
      if (nb > LANES) begin
         legal = 1'b0;
      end else if (whole_only) begin
         legal = (nb == LANES);
      end else begin
         mask  = OFF_W'(nb - 1);
         legal = ((off & mask) == '0);
      end
   end

endmodule

// File: rtl/idxp_lane_order.sv
module idxp_lane_order #(
   parameter int DATA_W = 32,
   parameter int SZ_W   = 2,
   localparam int LANES = DATA_W / 8
) (
   input  logic [DATA_W-1:0] din,
   input  logic [SZ_W-1:0]   size,
   input  logic              swap,
   output logic [DATA_W-1:0] dout
);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [7:0] lane_b;
      always_comb begin
         int n;
         int src;
         n = 1 << size;
         if (n > LANES) n = LANES;
         src    = swap ? (n - 1 - i) : i;
         lane_b = '0;
         if (i < n) lane_b = din[src*8 +: 8];
      end
      assign dout[i*8 +: 8] = lane_b;
   end

endmodule

// File: rtl/idxp_seq.sv
module idxp_seq
   import idxp_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic s_valid,
   input  logic s_write,
   input  logic local_only,
   input  logic d_ready,
   input  logic d_rvalid,
   output logic accept,
   output logic d_valid,
   output logic capture,
   output logic s_ready
);

   seq_e state_q, state_d;
   logic wr_q;

   assign accept  = (state_q == ST_IDLE) && s_valid;
   assign capture = (state_q == ST_WAIT) && d_rvalid;
   assign d_valid = (state_q == ST_ISSUE);
   assign s_ready = (state_q == ST_RESP);

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:  if (s_valid) state_d = local_only ? ST_RESP : ST_ISSUE;
         ST_ISSUE: if (d_ready) state_d = wr_q ? ST_RESP : ST_WAIT;
         ST_WAIT:  if (d_rvalid) state_d = ST_RESP;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         wr_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) wr_q <= s_write;
      end
   end

   // R12
   ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready |=> !s_ready);

   // R12
   ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      d_valid |-> !s_ready);

   // R8
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT && !d_rvalid) |=> !s_ready);

endmodule

// File: rtl/idxp_window_port.sv
module idxp_window_port
   import idxp_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8,
   localparam int OFF_W = $clog2(LANES),
   localparam int SZ_W  = $clog2($clog2(LANES) + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_valid,
   input  logic              s_write,
   input  logic [1:0]        s_tgt,
   input  logic [OFF_W-1:0]  s_off,
   input  logic [SZ_W-1:0]   s_size,
   input  logic [DATA_W-1:0] s_wdata,
   output logic              s_ready,
   output logic [DATA_W-1:0] s_rdata,
   output logic              s_err,
   output logic              d_valid,
   input  logic              d_ready,
   output logic              d_write,
   output logic              d_io,
   output logic [ADDR_W-1:0] d_addr,
   output logic [SZ_W-1:0]   d_size,
   output logic [DATA_W-1:0] d_wdata,
   input  logic              d_rvalid,
   input  logic [DATA_W-1:0] d_rdata
);

   localparam int WORD_SZ = $clog2(LANES);

   if (DATA_W % 8 != 0 || LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_data_w
      $error("DATA_W must be a power-of-two number of bytes, at least 2");
   end
   if (ADDR_W > DATA_W || ADDR_W <= OFF_W) begin : g_bad_addr_w
      $error("ADDR_W must fit the data path and exceed the offset width");
   end

   tgt_e tgt;
   logic is_index, is_data, legal, local_only;
   logic accept, capture;
   logic [DATA_W-1:0] wr_lanes, rd_lanes;

   logic [ADDR_W-1:0] idx_q;
   logic [DATA_W-1:0] rdata_q;
   logic              err_q;
   logic              write_q, io_q;
   logic [ADDR_W-1:0] addr_q;
   logic [SZ_W-1:0]   size_q;
   logic [DATA_W-1:0] wdata_q;

   assign tgt        = tgt_e'(s_tgt);
   assign is_index   = (tgt == TGT_INDEX);
   assign is_data    = (tgt == TGT_CFG) || (tgt == TGT_IO);
   assign local_only = !(is_data && legal);

   idxp_size_check #(.LANES(LANES), .OFF_W(OFF_W), .SZ_W(SZ_W)) i_size_check (
      .off        (s_off),
      .size       (s_size),
      .whole_only (is_index),
      .legal      (legal)
   );

   idxp_lane_order #(.DATA_W(DATA_W), .SZ_W(SZ_W)) i_wr_order (
      .din  (s_wdata),
      .size (s_size),
      .swap (tgt == TGT_IO),
      .dout (wr_lanes)
   );

   idxp_lane_order #(.DATA_W(DATA_W), .SZ_W(SZ_W)) i_rd_order (
      .din  (d_rdata),
      .size (size_q),
      .swap (io_q),
      .dout (rd_lanes)
   );

   idxp_seq i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .s_valid    (s_valid),
      .s_write    (s_write),
      .local_only (local_only),
      .d_ready    (d_ready),
      .d_rvalid   (d_rvalid),
      .accept     (accept),
      .d_valid    (d_valid),
      .capture    (capture),
      .s_ready    (s_ready)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q   <= '0;
         rdata_q <= '0;
         err_q   <= 1'b0;
         write_q <= 1'b0;
         io_q    <= 1'b0;
         addr_q  <= '0;
         size_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         write_q <= s_write;
         io_q    <= (tgt == TGT_IO);
         addr_q  <= {idx_q[ADDR_W-1:OFF_W], s_off};
         size_q  <= s_size;
         wdata_q <= wr_lanes;
         if (!local_only) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
         end else if (is_index && legal) begin
            err_q <= 1'b0;
            if (s_write) begin
               idx_q   <= s_wdata[ADDR_W-1:0];
               rdata_q <= '0;
            end else begin
               rdata_q <= DATA_W'(idx_q);
            end
         end else begin
            err_q   <= 1'b1;
            rdata_q <= '1;
         end
      end else if (capture) begin
         rdata_q <= rd_lanes;
      end
   end

   assign s_rdata = rdata_q;
   assign s_err   = err_q;
   assign d_write = write_q;
   assign d_io    = io_q;
   assign d_addr  = addr_q;
   assign d_size  = size_q;
   assign d_wdata = wdata_q;

   // R10
   d_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (d_valid && !d_ready) |=> (d_valid && $stable(d_addr) && $stable(d_size)
                                 && $stable(d_write) && $stable(d_io) && $stable(d_wdata)));

   // R3
   d_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      d_valid |-> (d_addr[ADDR_W-1:OFF_W] == idx_q[ADDR_W-1:OFF_W]));

   // R5
   d_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      d_valid |-> (((int'(d_addr[OFF_W-1:0]) & ((1 << d_size) - 1)) == 0)
                   && ((1 << d_size) <= LANES)));

   // R2
   err_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s_ready && s_err) |-> (&s_rdata));

   // R1
   idx_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(idx_q) |-> $past(accept && s_write && (s_tgt == 2'd0)
                                && (s_size == SZ_W'(WORD_SZ))));

endmodule

// File: tb/test_idxp_window_port.sv
module test_idxp_window_port;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        s_valid = 1'b0, s_write = 1'b0;
   logic [1:0]  s_tgt = '0, s_off = '0, s_size = '0;
   logic [31:0] s_wdata = '0;
   logic        s_ready, s_err;
   logic [31:0] s_rdata;
   logic        d_valid, d_write, d_io;
   logic        d_ready = 1'b0, d_rvalid = 1'b0;
   logic [31:0] d_addr, d_wdata;
   logic [31:0] d_rdata = 32'hDEAD_BEEF;
   logic [1:0]  d_size;

   int n_checks = 0;
   int n_fail   = 0;
   logic [31:0] idx_m = '0;

   typedef struct {
      logic [31:0] rdata;
      bit          err;
      bit          wr;
      int          kind;
      string       tag;
   } rsp_t;

   typedef struct {
      bit          io;
      bit          wr;
      logic [31:0] addr;
      logic [1:0]  size;
      logic [31:0] wdata;
      string       tag;
   } dreq_t;

   rsp_t  rsp_q[$];
   dreq_t dq[$];

   always #5 clk = ~clk;

   idxp_window_port i_idxp_window_port (
      .clk(clk), .rst_n(rst_n),
      .s_valid(s_valid), .s_write(s_write), .s_tgt(s_tgt), .s_off(s_off),
      .s_size(s_size), .s_wdata(s_wdata),
      .s_ready(s_ready), .s_rdata(s_rdata), .s_err(s_err),
      .d_valid(d_valid), .d_ready(d_ready), .d_write(d_write), .d_io(d_io),
      .d_addr(d_addr), .d_size(d_size), .d_wdata(d_wdata),
      .d_rvalid(d_rvalid), .d_rdata(d_rdata)
   );

   function automatic logic [31:0] ref_lanes(input logic [31:0] v, input int sz, input bit sw);
      int n;
      logic [31:0] r;
      n = 1 << sz;
      r = '0;
      for (int i = 0; i < n; i++) r[i*8 +: 8] = sw ? v[(n-1-i)*8 +: 8] : v[i*8 +: 8];
      return r;
   endfunction

   function automatic logic [31:0] rd_pattern(input logic [31:0] a);
      return {8'hE1 ^ a[7:0], 8'h7C, 8'h3B ^ a[15:8], 8'h42 ^ a[7:0]};
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic access(input logic [1:0] tgt, input bit wr, input logic [1:0] off,
                         input logic [1:0] sz, input logic [31:0] wd, input string tag);
      int  nb;
      bit  legal, io;
      logic [31:0] a;
      nb = 1 << sz;
      if (tgt == 2'd0)      legal = (nb == 4);
      else if (tgt == 2'd3) legal = 1'b0;
      else                  legal = (nb <= 4) && ((int'(off) % nb) == 0);
      if (!legal) begin
         rsp_q.push_back('{32'hFFFF_FFFF, 1'b1, wr, 0, tag});
      end else if (tgt == 2'd0) begin
         if (wr) begin
            idx_m = wd;
            rsp_q.push_back('{32'h0, 1'b0, 1'b1, 0, tag});
         end else begin
            rsp_q.push_back('{idx_m, 1'b0, 1'b0, 0, tag});
         end
      end else begin
         io = (tgt == 2'd2);
         a  = {idx_m[31:2], off};
         dq.push_back('{io, wr, a, sz, wr ? ref_lanes(wd, sz, io) : 32'h0, tag});
         if (wr) rsp_q.push_back('{32'h0, 1'b0, 1'b1, 2, tag});
         else    rsp_q.push_back('{ref_lanes(rd_pattern(a), sz, io), 1'b0, 1'b0, 1, tag});
      end
      @(negedge clk);
      s_valid = 1'b1; s_write = wr; s_tgt = tgt; s_off = off; s_size = sz; s_wdata = wd;
      do @(negedge clk); while (!s_ready);
      s_valid = 1'b0;
   endtask

   // monitor: pops the expected answer whenever the ready pulse shows
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (rst_n && s_ready) begin
            if (rsp_q.size() == 0) begin
               check(1'b0, "R12", "unexpected ready", 32'h1, 32'h0);
            end else begin
               rsp_t e;
               e = rsp_q.pop_front();
               check(s_err == e.err, e.tag, "error flag", 32'(s_err), 32'(e.err));
               if (!e.wr || e.err)
                  check(s_rdata == e.rdata, e.tag, "read data", s_rdata, e.rdata);
               // R8: answer follows the read strobe by one cycle
               if (e.kind == 1) check(d_rvalid === 1'b1, "R8", "rvalid before ready", 32'(d_rvalid), 32'h1);
               // R9: answer follows acceptance by one cycle
               if (e.kind == 2) check(d_ready === 1'b1, "R9", "accept before ready", 32'(d_ready), 32'h1);
            end
         end
      end
   end

   // downstream responder: compares each request with the expected queue
   initial begin
      int cnt;
      cnt = 0;
      forever begin
         @(negedge clk);
         if (rst_n && d_valid) begin
            bit          wr;
            logic [31:0] a;
            wr = d_write;
            a  = d_addr;
            cnt++;
            if (dq.size() == 0) begin
               // R5: nothing illegal may be forwarded
               check(1'b0, "R5", "unexpected downstream request", d_addr, 32'h0);
            end else begin
               dreq_t e;
               e = dq.pop_front();
               check(d_addr == e.addr, e.tag, "downstream address", d_addr, e.addr);
               check(d_io == e.io && d_write == e.wr && d_size == e.size, e.tag, "downstream kind",
                     {27'h0, d_io, d_write, 1'b0, d_size}, {27'h0, e.io, e.wr, 1'b0, e.size});
               if (e.wr) check(d_wdata == e.wdata, e.tag, "downstream lanes", d_wdata, e.wdata);
            end
            repeat (cnt % 3) @(negedge clk);
            d_ready = 1'b1;
            @(negedge clk);
            d_ready = 1'b0;
            if (!wr) begin
               repeat ((cnt + 1) % 3) @(negedge clk);
               d_rdata  = rd_pattern(a);
               d_rvalid = 1'b1;
               @(negedge clk);
               d_rvalid = 1'b0;
               d_rdata  = 32'hDEAD_BEEF;
            end
         end
      end
   end

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: idle outputs after reset
      check(s_ready == 1'b0 && d_valid == 1'b0, "R11", "idle after reset",
            {30'h0, s_ready, d_valid}, 32'h0);
      access(2'd0, 1'b0, 2'd0, 2'd2, 32'h0, "R11");

      // R1: raw index storage including low bits
      access(2'd0, 1'b1, 2'd0, 2'd2, 32'h1234_5677, "R1");
      access(2'd0, 1'b0, 2'd0, 2'd2, 32'h0, "R1");

      // R2: narrow index accesses refused, index kept
      access(2'd0, 1'b1, 2'd0, 2'd0, 32'hFFFF_FFFF, "R2");
      access(2'd0, 1'b0, 2'd0, 2'd1, 32'h0, "R2");
      access(2'd0, 1'b0, 2'd0, 2'd2, 32'h0, "R2");

      // R3 / R6: configuration reads and writes with bit 31 clear
      access(2'd1, 1'b0, 2'd0, 2'd2, 32'h0, "R3");
      access(2'd1, 1'b0, 2'd1, 2'd0, 32'h0, "R3");
      access(2'd1, 1'b1, 2'd2, 2'd1, 32'hABCD_1234, "R6");
      access(2'd1, 1'b1, 2'd0, 2'd2, 32'hCAFE_F00D, "R6");
      access(2'd1, 1'b0, 2'd2, 2'd1, 32'h0, "R6");

      // R7: I/O byte reversal
      access(2'd2, 1'b1, 2'd0, 2'd2, 32'h1122_3344, "R7");
      access(2'd2, 1'b1, 2'd2, 2'd1, 32'h0000_BEEF, "R7");
      access(2'd2, 1'b0, 2'd0, 2'd2, 32'h0, "R7");
      access(2'd2, 1'b0, 2'd0, 2'd1, 32'h0, "R7");
      access(2'd2, 1'b0, 2'd3, 2'd0, 32'h0, "R7");

      // R4 / R5: illegal sizes per offset, not forwarded
      access(2'd1, 1'b0, 2'd2, 2'd2, 32'h0, "R4");
      access(2'd1, 1'b1, 2'd1, 2'd1, 32'h5555_5555, "R4");
      access(2'd2, 1'b0, 2'd3, 2'd1, 32'h0, "R4");
      access(2'd2, 1'b0, 2'd1, 2'd2, 32'h0, "R5");
      access(2'd1, 1'b0, 2'd0, 2'd3, 32'h0, "R5");
      access(2'd3, 1'b0, 2'd0, 2'd2, 32'h0, "R5");
      access(2'd3, 1'b1, 2'd0, 2'd0, 32'h0, "R5");

      // R3: bit 31 set, still forwarded with the window offset
      access(2'd0, 1'b1, 2'd0, 2'd2, 32'h8000_0003, "R3");
      access(2'd0, 1'b0, 2'd0, 2'd2, 32'h0, "R1");
      access(2'd1, 1'b0, 2'd3, 2'd0, 32'h0, "R3");
      access(2'd1, 1'b1, 2'd1, 2'd0, 32'h0000_00A5, "R3");
      access(2'd2, 1'b0, 2'd2, 2'd1, 32'h0, "R9");
      access(2'd2, 1'b1, 2'd1, 2'd0, 32'h0000_0077, "R9");

      repeat (10) @(negedge clk);
      // R5: every expected downstream request was seen, no extra answers pending
      check(dq.size() == 0 && rsp_q.size() == 0, "R5", "queues drained",
            32'(dq.size() + rsp_q.size()), 32'h0);
      finish_run();
   end

endmodule